// File: doc/BRIEF.md
# Pad Deep-Sleep Output Controller

This block sits between the normal pad output path and the pads. Each pad has its own sleep enable and a 2-bit sleep mode. A one-cycle sleep-entry strobe puts every enabled pad into its sleep behaviour and sets that pad's status bit. The pad stays in sleep until software clears the status bit. While the status bit is clear, the pad's output and output enable pass straight through from the core side.

The enable and mode settings for each pad sit behind a lock bit. The lock resets to 1, and a clear request drops it to 0. After that, writes to the pad's settings have no effect until the next reset. The mode settings reset to the undriven mode and the enables reset to 0.

Top module: `pad_sleep_ctrl`

## Requirements
- R1: After reset, `status_o` is all zero, every lock bit on `lock_o` is 1, and `pad_out_o`/`pad_oe_o` equal `pad_out_i`/`pad_oe_i`.
- R2: A sleeping pad in mode 0 (2'b00) drives output 0 with output enable 1.
- R3: A sleeping pad in mode 1 (2'b01) drives output 1 with output enable 1.
- R4: A sleeping pad in mode 2 (2'b10) is undriven: output enable 0 and output 0.
- R5: A sleeping pad in mode 3 (2'b11) drives the `pad_out_i`/`pad_oe_i` values sampled at the clock edge where it entered sleep. This includes the undriven state (captured enable 0). Later input changes do not affect the pad.
- R6: When `sleep_entry_i` is 1 at a clock edge, every pad whose enable is 1 has its `status_o` bit set after that edge. Pads whose enable is 0 keep status 0 and pass their inputs through.
- R7: A pad's status bit stays 1 until `stat_clr_i` bit for that pad is 1 at a clock edge. After that edge the pad passes its inputs through again.
- R8: When a status clear and a sleep entry for an enabled pad occur at the same edge, the status bit is 1 after the edge.
- R9: `lock_clr_i` with `cfg_sel_i` = k sets lock bit k to 0 at the next edge. While lock bit k is 0, writes to pad k's enable and mode are ignored, and writes to other unlocked pads still take effect.
- R10: A settings write (`cfg_wr_i`) takes effect at its clock edge. A sleep entry at that same edge uses the settings held before the write.
- R11: A further sleep entry while a pad is already asleep does not re-capture its held values for mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pad_out_i | input | NumPads | Core-side output value per pad |
| pad_oe_i | input | NumPads | Core-side output enable per pad |
| sleep_entry_i | input | 1 | One-cycle deep-sleep entry strobe |
| cfg_wr_i | input | 1 | Write the enable and mode of pad `cfg_sel_i` |
| cfg_sel_i | input | SelW | Pad index for settings write or lock clear |
| cfg_en_i | input | 1 | Sleep enable value to write |
| cfg_mode_i | input | 2 | Sleep mode value to write |
| lock_clr_i | input | 1 | Clear the lock bit of pad `cfg_sel_i` |
| stat_clr_i | input | NumPads | Per-pad status clear request (1 clears) |
| pad_out_o | output | NumPads | Final pad output value |
| pad_oe_o | output | NumPads | Final pad output enable |
| status_o | output | NumPads | Per-pad sleep status |
| lock_o | output | NumPads | Per-pad settings lock (1 = writable) |

## Verification
Two events can fall in the same cycle: a software status clear and a sleep-entry strobe. The bench first puts the pads to sleep. It then raises `sleep_entry_i` together with `stat_clr_i` on an enabled pad, and expects that status bit to still read 1 after the edge.

A second collision is a settings write at the same edge as a sleep entry. It is judged by checking that the pad's status stays 0, because the enable written in that cycle is not yet in force. The pad then sleeps on the next strobe.

// File: rtl/pad_sleep_pkg.sv
package pad_sleep_pkg;

  typedef enum logic [1:0] {
    SlpTieLow  = 2'b00,
    SlpTieHigh = 2'b01,
    SlpFloat   = 2'b10,
    SlpHold    = 2'b11
  } slp_mode_e;

endpackage

// File: rtl/pad_sleep_cfg.sv
// Per-pad sleep enable/mode registers guarded by a sticky write lock.
module pad_sleep_cfg
  import pad_sleep_pkg::*;
#(
  parameter int NumPads = 8,
  parameter int SelW    = (NumPads > 1) ? $clog2(NumPads) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_wr_i,
  input  logic [SelW-1:0]            cfg_sel_i,
  input  logic                       cfg_en_i,
  input  slp_mode_e                  cfg_mode_i,
  input  logic                       lock_clr_i,
  output logic [NumPads-1:0]         sleep_en_o,
  output slp_mode_e [NumPads-1:0]    mode_o,
  output logic [NumPads-1:0]         lock_o
);

  for (genvar k = 0; k < NumPads; k++) begin : g_pad
    logic      hit;
    logic      en_q, en_d;
    slp_mode_e mode_q, mode_d;
    logic      lock_q, lock_d;

    assign hit = (cfg_sel_i == SelW'(k));

    always_comb begin
      en_d   = en_q;
      mode_d = mode_q;
      lock_d = lock_q;
      if (cfg_wr_i && hit && lock_q) begin
        en_d   = cfg_en_i;
        mode_d = cfg_mode_i;
      end
      if (lock_clr_i && hit) begin
        lock_d = 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        mode_q <= SlpFloat;
        lock_q <= 1'b1;
      end else begin
        en_q   <= en_d;
        mode_q <= mode_d;
        lock_q <= lock_d;
      end
    end

    assign sleep_en_o[k] = en_q;
    assign mode_o[k]     = mode_q;
    assign lock_o[k]     = lock_q;
  end

endmodule

// File: rtl/pad_sleep_lane.sv
// One pad: sleep status flag, entry-time capture and output override.
module pad_sleep_lane
  import pad_sleep_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      out_i,
  input  logic      oe_i,
  input  logic      entry_i,
  input  logic      en_i,
  input  slp_mode_e mode_i,
  input  logic      clr_i,
  output logic      out_o,
  output logic      oe_o,
  output logic      asleep_o
);

  logic status_q, status_d;
  logic cap_out_q, cap_oe_q;
  logic cap_en;
  logic enter;

  assign enter  = entry_i && en_i;
  // Capture only on the transition into sleep so a repeated strobe keeps the held state.
  assign cap_en = enter && !status_q;

  always_comb begin
    status_d = status_q;
    if (enter) begin
      status_d = 1'b1;       // set has priority over a same-cycle clear
    end else if (clr_i) begin
      status_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
    end else begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_out_q <= 1'b0;
      cap_oe_q  <= 1'b0;
    end else if (cap_en) begin
      cap_out_q <= out_i;
      cap_oe_q  <= oe_i;
    end
  end

  always_comb begin
    out_o = out_i;
    oe_o  = oe_i;
    if (status_q) begin
      unique case (mode_i)
        SlpTieLow:  begin out_o = 1'b0;      oe_o = 1'b1;     end
        SlpTieHigh: begin out_o = 1'b1;      oe_o = 1'b1;     end
        SlpFloat:   begin out_o = 1'b0;      oe_o = 1'b0;     end
        SlpHold:    begin out_o = cap_out_q; oe_o = cap_oe_q; end
        default:    begin out_o = 1'b0;      oe_o = 1'b0;     end
      endcase
    end
  end

  assign asleep_o = status_q;

endmodule

// File: rtl/pad_sleep_ctrl.sv
// Top: settings block plus one sleep lane per pad.
module pad_sleep_ctrl
  import pad_sleep_pkg::*;
#(
  parameter int NumPads = 8,
  localparam int SelW   = (NumPads > 1) ? $clog2(NumPads) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NumPads-1:0] pad_out_i,
  input  logic [NumPads-1:0] pad_oe_i,
  input  logic               sleep_entry_i,
  input  logic               cfg_wr_i,
  input  logic [SelW-1:0]    cfg_sel_i,
  input  logic               cfg_en_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic               lock_clr_i,
  input  logic [NumPads-1:0] stat_clr_i,
  output logic [NumPads-1:0] pad_out_o,
  output logic [NumPads-1:0] pad_oe_o,
  output logic [NumPads-1:0] status_o,
  output logic [NumPads-1:0] lock_o
);

  logic [NumPads-1:0]      sleep_en;
  slp_mode_e [NumPads-1:0] sleep_mode;

  pad_sleep_cfg #(
    .NumPads (NumPads),
    .SelW    (SelW)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_en_i   (cfg_en_i),
    .cfg_mode_i (slp_mode_e'(cfg_mode_i)),
    .lock_clr_i (lock_clr_i),
    .sleep_en_o (sleep_en),
    .mode_o     (sleep_mode),
    .lock_o     (lock_o)
  );

  for (genvar k = 0; k < NumPads; k++) begin : g_lane
    pad_sleep_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .out_i    (pad_out_i[k]),
      .oe_i     (pad_oe_i[k]),
      .entry_i  (sleep_entry_i),
      .en_i     (sleep_en[k]),
      .mode_i   (sleep_mode[k]),
      .clr_i    (stat_clr_i[k]),
      .out_o    (pad_out_o[k]),
      .oe_o     (pad_oe_o[k]),
      .asleep_o (status_o[k])
    );
  end

endmodule

// File: rtl/pad_sleep_ctrl_chk.sv
module pad_sleep_ctrl_chk
  import pad_sleep_pkg::*;
#(
  parameter int NumPads = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sleep_entry_i,
  input logic [NumPads-1:0]      stat_clr_i,
  input logic [NumPads-1:0]      status_o,
  input logic [NumPads-1:0]      pad_out_o,
  input logic [NumPads-1:0]      pad_oe_o,
  input logic [NumPads-1:0]      lock_o,
  input logic [NumPads-1:0]      sleep_en_i,
  input slp_mode_e [NumPads-1:0] mode_i
);

  for (genvar k = 0; k < NumPads; k++) begin : g_chk
    AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[k] && !stat_clr_i[k] |=> status_o[k]); // R7

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sleep_entry_i && sleep_en_i[k] |=> status_o[k]); // R8

    AST_RISE_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[k]) |-> $past(sleep_entry_i) && $past(sleep_en_i[k])); // R6

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lock_o[k] |=> !lock_o[k]); // R9

    AST_TIE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[k] && mode_i[k] == SlpTieLow |-> pad_oe_o[k] && !pad_out_o[k]); // R2

    AST_TIE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[k] && mode_i[k] == SlpTieHigh |-> pad_oe_o[k] && pad_out_o[k]); // R3

    AST_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[k] && mode_i[k] == SlpFloat |-> !pad_oe_o[k]); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[k] && $past(status_o[k]) && mode_i[k] == SlpHold &&
      $past(mode_i[k]) == SlpHold
      |-> $stable(pad_out_o[k]) && $stable(pad_oe_o[k])); // R5
  end

endmodule

bind pad_sleep_ctrl pad_sleep_ctrl_chk #(.NumPads(NumPads)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sleep_entry_i (sleep_entry_i),
  .stat_clr_i    (stat_clr_i),
  .status_o      (status_o),
  .pad_out_o     (pad_out_o),
  .pad_oe_o      (pad_oe_o),
  .lock_o        (lock_o),
  .sleep_en_i    (sleep_en),
  .mode_i        (sleep_mode)
);

// File: tb/tb_pad_sleep_ctrl.sv
module tb_pad_sleep_ctrl;

  localparam int ClkPeriod = 10;
  localparam int N         = 8;
  localparam int SW        = 3;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] pad_out_i, pad_oe_i, stat_clr;
  logic         sleep_entry, cfg_wr, cfg_en, lock_clr;
  logic [SW-1:0] cfg_sel;
  logic [1:0]   cfg_mode;
  logic [N-1:0] pad_out_o, pad_oe_o, status_o, lock_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  pad_sleep_ctrl #(.NumPads(N)) dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .pad_out_i     (pad_out_i),
    .pad_oe_i      (pad_oe_i),
    .sleep_entry_i (sleep_entry),
    .cfg_wr_i      (cfg_wr),
    .cfg_sel_i     (cfg_sel),
    .cfg_en_i      (cfg_en),
    .cfg_mode_i    (cfg_mode),
    .lock_clr_i    (lock_clr),
    .stat_clr_i    (stat_clr),
    .pad_out_o     (pad_out_o),
    .pad_oe_o      (pad_oe_o),
    .status_o      (status_o),
    .lock_o        (lock_o)
  );

  initial clk = 1'b0;
  always #(ClkPeriod / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input int idx, input logic en, input logic [1:0] mode);
    cfg_wr = 1'b1; cfg_sel = SW'(idx); cfg_en = en; cfg_mode = mode;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic enter_sleep();
    sleep_entry = 1'b1;
    tick();
    sleep_entry = 1'b0;
  endtask

  task automatic clear_status(input logic [N-1:0] mask);
    stat_clr = mask;
    tick();
    stat_clr = '0;
  endtask

  task automatic t_reset();
    pad_out_i = 8'h5A; pad_oe_i = 8'hC3;
    #1;
    check("R1 status", status_o, 8'h00);
    check("R1 lock", lock_o, 8'hFF);
    check("R1 out pass", pad_out_o, 8'h5A);
    check("R1 oe pass", pad_oe_o, 8'hC3);
  endtask

  task automatic t_modes();
    cfg_write(0, 1'b1, 2'b00);
    cfg_write(1, 1'b1, 2'b01);
    cfg_write(2, 1'b1, 2'b10);
    cfg_write(3, 1'b1, 2'b11);
    pad_out_i = 8'hFF; pad_oe_i = 8'hFF;
    enter_sleep();
    pad_out_i = 8'h00; pad_oe_i = 8'h00;
    #1;
    check("R6 status", status_o, 8'h0F);
    check("R2 pad0", {pad_out_o[0], pad_oe_o[0]}, 2'b01);
    check("R3 pad1", {pad_out_o[1], pad_oe_o[1]}, 2'b11);
    check("R4 pad2", {pad_out_o[2], pad_oe_o[2]}, 2'b00);
    check("R5 pad3 held", {pad_out_o[3], pad_oe_o[3]}, 2'b11);
    check("R6 disabled pads pass", {pad_out_o[7:4], pad_oe_o[7:4]}, 8'h00);
    pad_out_i = 8'hF0; pad_oe_i = 8'hF0;
    #1;
    check("R6 disabled pads follow", {pad_out_o[7:4], pad_oe_o[7:4]}, 8'hFF);
    pad_out_i = 8'h00; pad_oe_i = 8'h00;
  endtask

  task automatic t_recapture();
    enter_sleep();
    check("R11 pad3 not recaptured", {pad_out_o[3], pad_oe_o[3]}, 2'b11);
    check("R11 status", status_o, 8'h0F);
  endtask

  task automatic t_release();
    tick();
    check("R7 held without clear", status_o, 8'h0F);
    clear_status(8'h08);
    check("R7 status after clear", status_o, 8'h07);
    pad_out_i = 8'h08; pad_oe_i = 8'h00;
    #1;
    check("R7 pad3 passes", {pad_out_o[3], pad_oe_o[3]}, 2'b10);
    clear_status(8'hFF);
    check("R7 all clear", status_o, 8'h00);
  endtask

  task automatic t_keep_float();
    pad_out_i = 8'h08; pad_oe_i = 8'h00;
    enter_sleep();
    pad_out_i = 8'h00; pad_oe_i = 8'h08;
    #1;
    check("R5 held undriven", {pad_out_o[3], pad_oe_o[3]}, 2'b10);
    clear_status(8'hFF);
  endtask

  task automatic t_collide();
    enter_sleep();
    sleep_entry = 1'b1; stat_clr = 8'h0F;
    tick();
    sleep_entry = 1'b0; stat_clr = '0;
    check("R8 set wins over clear", status_o, 8'h0F);
    clear_status(8'hFF);
    check("R8 cleared afterwards", status_o, 8'h00);
  endtask

  task automatic t_lock();
    cfg_sel = 3'd0; lock_clr = 1'b1;
    tick();
    lock_clr = 1'b0;
    check("R9 lock bit", lock_o, 8'hFE);
    cfg_write(0, 1'b0, 2'b01);
    cfg_write(1, 1'b0, 2'b01);
    pad_out_i = 8'hFF; pad_oe_i = 8'hFF;
    enter_sleep();
    check("R9 status", status_o, 8'h0D);
    check("R9 locked pad0 kept mode0", {pad_out_o[0], pad_oe_o[0]}, 2'b01);
    check("R9 pad1 disabled passes", {pad_out_o[1], pad_oe_o[1]}, 2'b11);
    clear_status(8'hFF);
    check("R9 lock still clear", lock_o, 8'hFE);
  endtask

  task automatic t_write_timing();
    pad_out_i = 8'h00; pad_oe_i = 8'hFF;
    cfg_wr = 1'b1; cfg_sel = 3'd5; cfg_en = 1'b1; cfg_mode = 2'b01;
    sleep_entry = 1'b1;
    tick();
    cfg_wr = 1'b0; sleep_entry = 1'b0;
    check("R10 old enable used", status_o[5], 1'b0);
    clear_status(8'hFF);
    enter_sleep();
    check("R10 new enable used", status_o[5], 1'b1);
    check("R10 new mode drives high", {pad_out_o[5], pad_oe_o[5]}, 2'b11);
    clear_status(8'hFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pad_out_i = '0; pad_oe_i = '0; stat_clr = '0;
    sleep_entry = 1'b0; cfg_wr = 1'b0; cfg_en = 1'b0; lock_clr = 1'b0;
    cfg_sel = '0; cfg_mode = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_modes();
    t_recapture();
    t_release();
    t_keep_float();
    t_collide();
    t_lock();
    t_write_timing();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule